// File: doc/BRIEF.md
# Ethernet DMA Control and Status Registers

This block is the software-facing register file of an Ethernet DMA controller. Software reaches it through a 32-bit register bus that is addressed in words; the word index is the byte address divided by four. Word indices range over a 4 KiB window, and the DMA registers occupy indices 0x3C0 through 0x3D6. The block holds the bus mode word, the run control word, the interrupt mask, the event status word, and, for each ring (receive and transmit), a base address and the address of the descriptor currently in use.

The transmit and receive engines report events as single-cycle pulses. Each pulse sets bits in the status word. Software clears those bits by writing ones to them. One level interrupt is raised while any enabled status bit is set. Writes to the poll registers become one-cycle kick strobes to the engines. The run bits of the control word drive the engines' enable inputs. The engines move the current-descriptor pointers forward, or return them to the ring base, through dedicated pulse inputs.

Top module: `eth_dma_csr`

## Requirements
- R1: After synchronous reset every stored register reads 0. The irq, tx_kick, rx_kick, soft_rst, tx_run and rx_run outputs are low.
- R2: A write to the status word (index 0x3C5) clears each status bit whose write-data bit is 1 and leaves every other status bit unchanged.
- R3: irq is high exactly when the status word ANDed with the interrupt mask (index 0x3C7) is nonzero. It follows the register state in the cycle after a write or an engine event.
- R4: If an engine event sets a status bit in the same cycle that a software write clears it, the bit ends up set.
- R5: A write to the receive ring base (index 0x3C3) or the transmit ring base (index 0x3C4) stores the value in that base register and also in the matching current-descriptor pointer. That pointer is readable at index 0x3D3 (receive) or 0x3D2 (transmit) and appears on rx_desc_cur or tx_desc_cur.
- R6: The bus mode word (index 0x3C0) stores every write-data bit except bit 0, which always reads 0. Writing 1 to bit 0 raises soft_rst for exactly one cycle.
- R7: Index 0x008 always reads 0x1012. Writes to it have no effect.
- R8: A write to index 0x3C1 raises tx_kick for one cycle, and a write to index 0x3C2 raises rx_kick for one cycle. Both indices read as 0.
- R9: In the control word (index 0x3C6), bit 1 drives rx_run and bit 13 drives tx_run.
- R10: The event inputs set these status bits: tx_done_evt sets bits 0 and 16, tx_nodesc_evt sets bits 2 and 15, rx_done_evt sets bits 6 and 16, and rx_nodesc_evt sets bits 7 and 15.
- R11: An advance pulse adds DESC_BYTES (default 32) to that ring's current pointer. A wrap pulse reloads the pointer from the ring base and takes priority over an advance. A base write in the same cycle overrides both.
- R12: Indices with no defined register read 0, and writes to them are ignored. The current-descriptor pointers cannot be written from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe; data appears one cycle later |
| csr_addr | input | WORD_AW (10) | Word index |
| csr_wdata | input | DATA_W (32) | Write data |
| csr_rdata | output | DATA_W (32) | Registered read data |
| tx_done_evt | input | 1 | Transmit frame finished |
| tx_nodesc_evt | input | 1 | Transmit found no owned descriptor |
| rx_done_evt | input | 1 | Receive frame stored |
| rx_nodesc_evt | input | 1 | Receive found no owned descriptor |
| tx_desc_adv | input | 1 | Step transmit pointer by one descriptor |
| tx_desc_wrap | input | 1 | Return transmit pointer to its base |
| rx_desc_adv | input | 1 | Step receive pointer by one descriptor |
| rx_desc_wrap | input | 1 | Return receive pointer to its base |
| tx_kick | output | 1 | One-cycle transmit poll strobe |
| rx_kick | output | 1 | One-cycle receive poll strobe |
| tx_run | output | 1 | Transmit engine enable |
| rx_run | output | 1 | Receive engine enable |
| soft_rst | output | 1 | One-cycle soft reset strobe |
| bus_cfg | output | DATA_W (32) | Stored bus mode word |
| tx_desc_cur | output | DATA_W (32) | Current transmit descriptor address |
| rx_desc_cur | output | DATA_W (32) | Current receive descriptor address |
| irq | output | 1 | Level interrupt |

## Verification
Two collisions matter most. The first is a software write-one-to-clear of the whole status word in the same cycle as an engine event. The bench drives both on one clock edge and expects exactly the event's bits to survive. The second is a ring base write in the same cycle as an engine advance pulse. There the bench expects the current pointer to equal the newly written base rather than the old pointer plus one descriptor.

// File: rtl/eth_dma_csr_pkg.sv
package eth_dma_csr_pkg;

    localparam int IDX_VERSION  = 'h008;
    localparam int IDX_BUS_MODE = 'h3C0;
    localparam int IDX_TX_POLL  = 'h3C1;
    localparam int IDX_RX_POLL  = 'h3C2;
    localparam int IDX_RX_BASE  = 'h3C3;
    localparam int IDX_TX_BASE  = 'h3C4;
    localparam int IDX_STATUS   = 'h3C5;
    localparam int IDX_CONTROL  = 'h3C6;
    localparam int IDX_INT_MASK = 'h3C7;
    localparam int IDX_CUR_TX   = 'h3D2;
    localparam int IDX_CUR_RX   = 'h3D3;

    localparam logic [31:0] VERSION_WORD = 32'h0000_1012;

    localparam int BIT_TX_DONE   = 0;
    localparam int BIT_TX_NODESC = 2;
    localparam int BIT_RX_DONE   = 6;
    localparam int BIT_RX_NODESC = 7;
    localparam int BIT_ABNORMAL  = 15;
    localparam int BIT_NORMAL    = 16;

    localparam int CTL_RX_RUN = 1;
    localparam int CTL_TX_RUN = 13;

    typedef enum logic {RING_RX = 1'b0, RING_TX = 1'b1} ring_e;
    localparam int NUM_RINGS = 2;

    typedef struct packed {
        logic tx_done;
        logic tx_nodesc;
        logic rx_done;
        logic rx_nodesc;
    } dma_evt_t;

    function automatic logic [31:0] evt_set_mask(dma_evt_t e);
        logic [31:0] m;
        m = '0;
        if (e.tx_done) begin
            m[BIT_TX_DONE] = 1'b1;
            m[BIT_NORMAL]  = 1'b1;
        end
        if (e.rx_done) begin
            m[BIT_RX_DONE] = 1'b1;
            m[BIT_NORMAL]  = 1'b1;
        end
        if (e.tx_nodesc) begin
            m[BIT_TX_NODESC] = 1'b1;
            m[BIT_ABNORMAL]  = 1'b1;
        end
        if (e.rx_nodesc) begin
            m[BIT_RX_NODESC] = 1'b1;
            m[BIT_ABNORMAL]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_stat_reg.sv
module dma_stat_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] en_mask,
    output logic [DATA_W-1:0] stat_q,
    output logic              irq
);

    logic [DATA_W-1:0] keep_mask;

    always_comb begin
        keep_mask = clr_wr ? ~clr_mask : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & keep_mask) | set_mask;
        end
    end

    assign irq = |(stat_q & en_mask);

    a_r2_clear_ones: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((stat_q & $past(clr_mask & ~set_mask)) == '0));

    a_r2_keep_zeros: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((stat_q & $past(~clr_mask & stat_q)) == $past(~clr_mask & stat_q)));

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((stat_q & $past(set_mask)) == $past(set_mask)));

    a_r3_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && set_mask == '0) |=> (!$stable(en_mask) || $stable(irq)));

endmodule

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr #(
    parameter int DATA_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_wr,
    input  logic [DATA_W-1:0] base_wdata,
    input  logic              adv,
    input  logic              wrap,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else if (base_wr) begin
            base_q <= base_wdata;
            cur_q  <= base_wdata;
        end else if (wrap) begin
            cur_q <= base_q;
        end else if (adv) begin
            cur_q <= cur_q + STEP;
        end
    end

    a_r5_base_reload: assert property (@(posedge clk) disable iff (rst)
        base_wr |=> (cur_q == base_q));

    a_r11_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
        (wrap && !base_wr) |=> (cur_q == $past(base_q)));

    a_r11_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !wrap && !base_wr) |=> (cur_q == $past(cur_q) + STEP));

endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
    import eth_dma_csr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WORD_AW    = 10,
    parameter int DESC_BYTES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_wr,
    input  logic               csr_rd,
    input  logic [WORD_AW-1:0] csr_addr,
    input  logic [DATA_W-1:0]  csr_wdata,
    output logic [DATA_W-1:0]  csr_rdata,
    input  logic               tx_done_evt,
    input  logic               tx_nodesc_evt,
    input  logic               rx_done_evt,
    input  logic               rx_nodesc_evt,
    input  logic               tx_desc_adv,
    input  logic               tx_desc_wrap,
    input  logic               rx_desc_adv,
    input  logic               rx_desc_wrap,
    output logic               tx_kick,
    output logic               rx_kick,
    output logic               tx_run,
    output logic               rx_run,
    output logic               soft_rst,
    output logic [DATA_W-1:0]  bus_cfg,
    output logic [DATA_W-1:0]  tx_desc_cur,
    output logic [DATA_W-1:0]  rx_desc_cur,
    output logic               irq
);

    localparam logic [WORD_AW-1:0] A_VERSION  = WORD_AW'(IDX_VERSION);
    localparam logic [WORD_AW-1:0] A_BUS_MODE = WORD_AW'(IDX_BUS_MODE);
    localparam logic [WORD_AW-1:0] A_TX_POLL  = WORD_AW'(IDX_TX_POLL);
    localparam logic [WORD_AW-1:0] A_RX_POLL  = WORD_AW'(IDX_RX_POLL);
    localparam logic [WORD_AW-1:0] A_RX_BASE  = WORD_AW'(IDX_RX_BASE);
    localparam logic [WORD_AW-1:0] A_TX_BASE  = WORD_AW'(IDX_TX_BASE);
    localparam logic [WORD_AW-1:0] A_STATUS   = WORD_AW'(IDX_STATUS);
    localparam logic [WORD_AW-1:0] A_CONTROL  = WORD_AW'(IDX_CONTROL);
    localparam logic [WORD_AW-1:0] A_INT_MASK = WORD_AW'(IDX_INT_MASK);
    localparam logic [WORD_AW-1:0] A_CUR_TX   = WORD_AW'(IDX_CUR_TX);
    localparam logic [WORD_AW-1:0] A_CUR_RX   = WORD_AW'(IDX_CUR_RX);

    dma_evt_t          evt;
    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] bus_q;
    logic [DATA_W-1:0] ctl_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rd_mux;
    logic              tx_kick_q;
    logic              rx_kick_q;
    logic              srst_q;

    logic [NUM_RINGS-1:0]             ring_base_wr;
    logic [NUM_RINGS-1:0]             ring_adv;
    logic [NUM_RINGS-1:0]             ring_wrap;
    logic [NUM_RINGS-1:0][DATA_W-1:0] ring_base;
    logic [NUM_RINGS-1:0][DATA_W-1:0] ring_cur;

    assign evt = '{tx_done: tx_done_evt, tx_nodesc: tx_nodesc_evt,
                   rx_done: rx_done_evt, rx_nodesc: rx_nodesc_evt};
    assign set_mask = DATA_W'(evt_set_mask(evt));

    dma_stat_reg #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_wr   (csr_wr && csr_addr == A_STATUS),
        .clr_mask (csr_wdata),
        .set_mask (set_mask),
        .en_mask  (mask_q),
        .stat_q   (stat_q),
        .irq      (irq)
    );

    assign ring_base_wr[RING_RX] = csr_wr && csr_addr == A_RX_BASE;
    assign ring_base_wr[RING_TX] = csr_wr && csr_addr == A_TX_BASE;
    assign ring_adv[RING_RX]     = rx_desc_adv;
    assign ring_adv[RING_TX]     = tx_desc_adv;
    assign ring_wrap[RING_RX]    = rx_desc_wrap;
    assign ring_wrap[RING_TX]    = tx_desc_wrap;

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        dma_ring_ptr #(.DATA_W(DATA_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
            .clk        (clk),
            .rst        (rst),
            .base_wr    (ring_base_wr[g]),
            .base_wdata (csr_wdata),
            .adv        (ring_adv[g]),
            .wrap       (ring_wrap[g]),
            .base_q     (ring_base[g]),
            .cur_q      (ring_cur[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q     <= '0;
            ctl_q     <= '0;
            mask_q    <= '0;
            tx_kick_q <= 1'b0;
            rx_kick_q <= 1'b0;
            srst_q    <= 1'b0;
        end else begin
            tx_kick_q <= csr_wr && csr_addr == A_TX_POLL;
            rx_kick_q <= csr_wr && csr_addr == A_RX_POLL;
            srst_q    <= csr_wr && csr_addr == A_BUS_MODE && csr_wdata[0];
            if (csr_wr) begin
                unique case (csr_addr)
                    A_BUS_MODE: bus_q  <= {csr_wdata[DATA_W-1:1], 1'b0};
                    A_CONTROL:  ctl_q  <= csr_wdata;
                    A_INT_MASK: mask_q <= csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (csr_addr)
            A_VERSION:  rd_mux = DATA_W'(VERSION_WORD);
            A_BUS_MODE: rd_mux = bus_q;
            A_RX_BASE:  rd_mux = ring_base[RING_RX];
            A_TX_BASE:  rd_mux = ring_base[RING_TX];
            A_STATUS:   rd_mux = stat_q;
            A_CONTROL:  rd_mux = ctl_q;
            A_INT_MASK: rd_mux = mask_q;
            A_CUR_TX:   rd_mux = ring_cur[RING_TX];
            A_CUR_RX:   rd_mux = ring_cur[RING_RX];
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_rdata <= '0;
        end else if (csr_rd) begin
            csr_rdata <= rd_mux;
        end
    end

    assign tx_kick     = tx_kick_q;
    assign rx_kick     = rx_kick_q;
    assign soft_rst    = srst_q;
    assign tx_run      = ctl_q[CTL_TX_RUN];
    assign rx_run      = ctl_q[CTL_RX_RUN];
    assign bus_cfg     = bus_q;
    assign tx_desc_cur = ring_cur[RING_TX];
    assign rx_desc_cur = ring_cur[RING_RX];

    a_r8_tx_kick_cause: assert property (@(posedge clk) disable iff (rst)
        tx_kick |-> $past(csr_wr));

    a_r8_rx_kick_cause: assert property (@(posedge clk) disable iff (rst)
        rx_kick |-> $past(csr_wr));

    a_r6_srst_cause: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> $past(csr_wr && csr_wdata[0]));

    a_r12_cur_readonly: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_addr == A_CUR_RX && !rx_desc_adv && !rx_desc_wrap) |=>
            $stable(rx_desc_cur));

endmodule

// File: tb/sim_eth_dma_csr.sv
module sim_eth_dma_csr;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_wr, csr_rd;
    logic [9:0]  csr_addr;
    logic [31:0] csr_wdata, csr_rdata;
    logic        tx_done_evt, tx_nodesc_evt, rx_done_evt, rx_nodesc_evt;
    logic        tx_desc_adv, tx_desc_wrap, rx_desc_adv, rx_desc_wrap;
    logic        tx_kick, rx_kick, tx_run, rx_run, soft_rst, irq;
    logic [31:0] bus_cfg, tx_desc_cur, rx_desc_cur;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_dma_csr u0 (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .tx_done_evt(tx_done_evt), .tx_nodesc_evt(tx_nodesc_evt),
        .rx_done_evt(rx_done_evt), .rx_nodesc_evt(rx_nodesc_evt),
        .tx_desc_adv(tx_desc_adv), .tx_desc_wrap(tx_desc_wrap),
        .rx_desc_adv(rx_desc_adv), .rx_desc_wrap(rx_desc_wrap),
        .tx_kick(tx_kick), .rx_kick(rx_kick), .tx_run(tx_run), .rx_run(rx_run),
        .soft_rst(soft_rst), .bus_cfg(bus_cfg), .tx_desc_cur(tx_desc_cur),
        .rx_desc_cur(rx_desc_cur), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        csr_wr = 0; csr_rd = 0; csr_addr = '0; csr_wdata = '0;
        tx_done_evt = 0; tx_nodesc_evt = 0; rx_done_evt = 0; rx_nodesc_evt = 0;
        tx_desc_adv = 0; tx_desc_wrap = 0; rx_desc_adv = 0; rx_desc_wrap = 0;
    endtask

    // drive at a falling edge, commit on the next rising edge, return at the following falling edge
    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        csr_wr = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_rd = 1; csr_addr = a;
        @(negedge clk);
        d = csr_rdata;
        csr_rd = 0;
    endtask

    task automatic rd_chk(string req, logic [9:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 kicks", {30'b0, tx_kick, rx_kick}, 0);
        chk("R1 run", {30'b0, tx_run, rx_run}, 0);
        chk("R1 soft_rst", {31'b0, soft_rst}, 0);
        rd_chk("R1 status", 10'h3C5, 0);
        rd_chk("R1 bus mode", 10'h3C0, 0);
        rd_chk("R1 rx base", 10'h3C3, 0);
    endtask

    task automatic t_version();
        rd_chk("R7 version", 10'h008, 32'h1012);
        wr(10'h008, 32'hDEAD_BEEF);
        rd_chk("R7 version after write", 10'h008, 32'h1012);
    endtask

    task automatic t_bus_mode();
        @(negedge clk);
        csr_wr = 1; csr_addr = 10'h3C0; csr_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        csr_wr = 0;
        chk("R6 soft_rst pulse", {31'b0, soft_rst}, 1);
        @(negedge clk);
        chk("R6 soft_rst one cycle", {31'b0, soft_rst}, 0);
        rd_chk("R6 bit0 reads 0", 10'h3C0, 32'hFFFF_FFFE);
        chk("R6 bus_cfg", bus_cfg, 32'hFFFF_FFFE);
        wr(10'h3C0, 32'h0000_0A00);
        chk("R6 no pulse when bit0 low", {31'b0, soft_rst}, 0);
    endtask

    task automatic t_control();
        wr(10'h3C6, 32'h0000_2002);
        chk("R9 both run", {30'b0, tx_run, rx_run}, 2'b11);
        wr(10'h3C6, 32'h0000_0002);
        chk("R9 rx only", {30'b0, tx_run, rx_run}, 2'b01);
        wr(10'h3C6, 32'h0000_2000);
        chk("R9 tx only", {30'b0, tx_run, rx_run}, 2'b10);
    endtask

    task automatic t_poll();
        wr(10'h3C1, 32'h1);
        chk("R8 tx kick", {30'b0, tx_kick, rx_kick}, 2'b10);
        @(negedge clk);
        chk("R8 tx kick one cycle", {30'b0, tx_kick, rx_kick}, 2'b00);
        wr(10'h3C2, 32'h0);
        chk("R8 rx kick", {30'b0, tx_kick, rx_kick}, 2'b01);
        @(negedge clk);
        chk("R8 rx kick one cycle", {30'b0, tx_kick, rx_kick}, 2'b00);
        rd_chk("R8 poll reads 0", 10'h3C1, 0);
    endtask

    task automatic pulse_evt(int which);
        @(negedge clk);
        case (which)
            0: tx_done_evt = 1;
            1: tx_nodesc_evt = 1;
            2: rx_done_evt = 1;
            default: rx_nodesc_evt = 1;
        endcase
        @(negedge clk);
        tx_done_evt = 0; tx_nodesc_evt = 0; rx_done_evt = 0; rx_nodesc_evt = 0;
    endtask

    task automatic t_events();
        pulse_evt(0);
        rd_chk("R10 tx_done bits", 10'h3C5, 32'h0001_0001);
        chk("R3 masked irq low", {31'b0, irq}, 0);
        pulse_evt(3);
        rd_chk("R10 rx_nodesc bits", 10'h3C5, 32'h0001_8081);
        pulse_evt(1);
        rd_chk("R10 tx_nodesc bits", 10'h3C5, 32'h0001_8085);
        pulse_evt(2);
        rd_chk("R10 rx_done bits", 10'h3C5, 32'h0001_80C5);
    endtask

    task automatic t_w1c();
        wr(10'h3C5, 32'h0000_8001);
        rd_chk("R2 clear selected", 10'h3C5, 32'h0001_00C4);
        wr(10'h3C5, 32'h0000_0000);
        rd_chk("R2 zero write keeps", 10'h3C5, 32'h0001_00C4);
    endtask

    task automatic t_irq();
        wr(10'h3C7, 32'h0000_0040);
        chk("R3 irq on mask", {31'b0, irq}, 1);
        wr(10'h3C5, 32'h0000_0040);
        chk("R3 irq off after clear", {31'b0, irq}, 0);
        wr(10'h3C7, 32'h0000_0001);
        chk("R3 irq masked", {31'b0, irq}, 0);
        pulse_evt(0);
        chk("R3 irq on event", {31'b0, irq}, 1);
        wr(10'h3C5, 32'hFFFF_FFFF);
        chk("R3 irq off all clear", {31'b0, irq}, 0);
        rd_chk("R2 all clear", 10'h3C5, 0);
    endtask

    task automatic t_set_wins();
        pulse_evt(0);
        @(negedge clk);
        csr_wr = 1; csr_addr = 10'h3C5; csr_wdata = 32'hFFFF_FFFF;
        rx_done_evt = 1;
        @(negedge clk);
        csr_wr = 0; rx_done_evt = 0;
        rd_chk("R4 event beats clear", 10'h3C5, 32'h0001_0040);
        @(negedge clk);
        csr_wr = 1; csr_addr = 10'h3C5; csr_wdata = 32'h0000_0001;
        tx_done_evt = 1;
        @(negedge clk);
        csr_wr = 0; tx_done_evt = 0;
        rd_chk("R4 same bit kept", 10'h3C5, 32'h0001_0041);
        chk("R4 irq held", {31'b0, irq}, 1);
    endtask

    task automatic t_rings();
        wr(10'h3C3, 32'h0000_1000);
        rd_chk("R5 rx cur loaded", 10'h3D3, 32'h0000_1000);
        chk("R5 rx port", rx_desc_cur, 32'h0000_1000);
        rd_chk("R5 rx base", 10'h3C3, 32'h0000_1000);
        wr(10'h3C4, 32'h0000_0300);
        chk("R5 tx port", tx_desc_cur, 32'h0000_0300);
        @(negedge clk); rx_desc_adv = 1;
        @(negedge clk); @(negedge clk); rx_desc_adv = 0;
        chk("R11 rx two steps", rx_desc_cur, 32'h0000_1040);
        @(negedge clk); tx_desc_adv = 1;
        @(negedge clk); tx_desc_adv = 0;
        rd_chk("R11 tx step", 10'h3D2, 32'h0000_0320);
        rd_chk("R11 tx base unchanged", 10'h3C4, 32'h0000_0300);
        @(negedge clk); rx_desc_wrap = 1; rx_desc_adv = 1;
        @(negedge clk); rx_desc_wrap = 0; rx_desc_adv = 0;
        chk("R11 wrap beats advance", rx_desc_cur, 32'h0000_1000);
        @(negedge clk);
        csr_wr = 1; csr_addr = 10'h3C3; csr_wdata = 32'h0000_2000; rx_desc_adv = 1;
        @(negedge clk);
        csr_wr = 0; rx_desc_adv = 0;
        chk("R11 base write beats advance", rx_desc_cur, 32'h0000_2000);
    endtask

    task automatic t_undefined();
        wr(10'h3D0, 32'h0000_1234);
        rd_chk("R12 undefined reads 0", 10'h3D0, 0);
        rd_chk("R12 top index 0", 10'h3FF, 0);
        wr(10'h3D3, 32'h0000_5555);
        rd_chk("R12 cur rx not writable", 10'h3D3, 32'h0000_2000);
        wr(10'h3D2, 32'h0000_7777);
        chk("R12 cur tx not writable", tx_desc_cur, 32'h0000_0320);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_version();
        t_bus_mode();
        t_control();
        t_poll();
        t_events();
        t_w1c();
        t_irq();
        t_set_wins();
        t_rings();
        t_undefined();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule